// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block manages 128 general-purpose pins, grouped as four banks of 32. Software reaches it through a request/response register port. Each bank holds the following state:
- a direction mask;
- an output latch, changed only through a set port and a clear port, each of which acts on the bits written as one;
- rising-edge and falling-edge enable masks;
- a sticky edge-event register, cleared by writing ones;
- two alternate-function words, which are stored but not acted on.

A level view returns the driven value on output pins and the synchronized pad value on input pins. The per-bank offsets do not form a regular stride, so the decoder matches every mapped word exactly.

Requests enter on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response on the `rsp_*` channel one cycle later. A response stays on the channel, unchanged, until the consumer raises `rsp_ready`. `req_ready` is high whenever no response is waiting or the waiting response is being taken in the same cycle. A consumer that holds `rsp_ready` low therefore stalls the request side after one outstanding response.

Top module: `bgpio_ctrl`

## Requirements
- R1: After reset all registers are zero: every pin is an input (`pin_oe` all zero), `pin_out` is zero, no response is pending and `req_ready` is high.
- R2: A write to a bank's set word ORs the data into that bank's output latch. Reading the set word returns the last value written to it.
- R3: A write to a bank's clear word clears each latch bit where the data has a one. Reading the clear word returns the fixed pattern 0xAAAAAAAA (bit pairs `10`).
- R4: Reading a bank's level word returns latch AND direction, ORed with the synchronized pin input AND NOT direction. Pin inputs pass through two flops before they are used.
- R5: `pin_oe` equals the direction bits. `pin_out` equals latch AND direction, so a pin switched to input stops driving.
- R6: Word offsets, listed as banks 0/1/2/3:
  - level: 0x000/0x004/0x008/0x100
  - direction: 0x00C/0x010/0x014/0x10C
  - set: 0x018/0x01C/0x020/0x118
  - clear: 0x024/0x028/0x02C/0x124
  - rise enable: 0x030/0x034/0x038/0x130
  - fall enable: 0x03C/0x040/0x044/0x13C
  - edge events: 0x048/0x04C/0x050/0x148
  - alt-low: 0x054/0x05C/0x064/0x06C
  - alt-high: 0x058/0x060/0x068/0x070

  Direction, the enables and the alt words read back what was written, and banks are independent.
- R7: An event bit is set when its synchronized input rises with rise enable on, or falls with fall enable on, and the pin is an input. The bit stays set until it is cleared. Output pins never record events.
- R8: Writing the edge-event word clears the bits written as one. An event arriving in the same cycle wins over the clear.
- R9: A request to any other offset, including an unaligned one, returns `rsp_err`=1 with zero data and changes no state. Mapped requests return `rsp_err`=0, and writes return zero data.
- R10: Each accepted request yields one response, in order. While `rsp_valid` is high and `rsp_ready` is low, data and error are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request accepted on this edge when high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | byte offset |
| req_wdata | input | 32 | write data |
| rsp_valid | output | 1 | response present |
| rsp_ready | input | 1 | consumer takes response |
| rsp_rdata | output | 32 | read data (zero for writes and errors) |
| rsp_err | output | 1 | unmapped offset |
| pin_in | input | 128 | pad inputs, bank b at bits 32b+31..32b |
| pin_oe | output | 128 | output enables |
| pin_out | output | 128 | output values |

## Verification
On every cycle, the assertions check the following:
- a pin is never driven high while its enable is off;
- the pins move only after an accepted write;
- a stalled response holds still, and each acceptance is answered on the next cycle;
- error responses carry zero data;
- reset leaves every pin undriven.

Only the bench scenarios can show the rest. These cover the exact offset map, the set and clear arithmetic, the level mixing of latch and pad, and edge capture on input pins against output pins. They also cover clearing of the edge-event word, and the fact that unmapped writes leave the direction and latch state untouched.

// File: rtl/bgp_pkg.sv
package bgp_pkg;
  localparam int BGP_NBANK = 4;
  localparam int BGP_BANK_W = 2;

  typedef enum logic [3:0] {
    K_LVL, K_DIR, K_SET, K_CLR, K_REN, K_FEN, K_EDG, K_AFL, K_AFU
  } bgp_kind_e;

  typedef struct packed {
    logic                  hit;
    bgp_kind_e             kind;
    logic [BGP_BANK_W-1:0] bank;
  } bgp_dec_t;

  function automatic bgp_dec_t bgp_map(input logic [31:0] a);
    bgp_dec_t r;
    r.hit  = 1'b1;
    r.kind = K_LVL;
    r.bank = '0;
    case (a)
      32'h000: begin r.kind = K_LVL; r.bank = 2'd0; end
      32'h004: begin r.kind = K_LVL; r.bank = 2'd1; end
      32'h008: begin r.kind = K_LVL; r.bank = 2'd2; end
      32'h100: begin r.kind = K_LVL; r.bank = 2'd3; end
      32'h00C: begin r.kind = K_DIR; r.bank = 2'd0; end
      32'h010: begin r.kind = K_DIR; r.bank = 2'd1; end
      32'h014: begin r.kind = K_DIR; r.bank = 2'd2; end
      32'h10C: begin r.kind = K_DIR; r.bank = 2'd3; end
      32'h018: begin r.kind = K_SET; r.bank = 2'd0; end
      32'h01C: begin r.kind = K_SET; r.bank = 2'd1; end
      32'h020: begin r.kind = K_SET; r.bank = 2'd2; end
      32'h118: begin r.kind = K_SET; r.bank = 2'd3; end
      32'h024: begin r.kind = K_CLR; r.bank = 2'd0; end
      32'h028: begin r.kind = K_CLR; r.bank = 2'd1; end
      32'h02C: begin r.kind = K_CLR; r.bank = 2'd2; end
      32'h124: begin r.kind = K_CLR; r.bank = 2'd3; end
      32'h030: begin r.kind = K_REN; r.bank = 2'd0; end
      32'h034: begin r.kind = K_REN; r.bank = 2'd1; end
      32'h038: begin r.kind = K_REN; r.bank = 2'd2; end
      32'h130: begin r.kind = K_REN; r.bank = 2'd3; end
      32'h03C: begin r.kind = K_FEN; r.bank = 2'd0; end
      32'h040: begin r.kind = K_FEN; r.bank = 2'd1; end
      32'h044: begin r.kind = K_FEN; r.bank = 2'd2; end
      32'h13C: begin r.kind = K_FEN; r.bank = 2'd3; end
      32'h048: begin r.kind = K_EDG; r.bank = 2'd0; end
      32'h04C: begin r.kind = K_EDG; r.bank = 2'd1; end
      32'h050: begin r.kind = K_EDG; r.bank = 2'd2; end
      32'h148: begin r.kind = K_EDG; r.bank = 2'd3; end
      32'h054: begin r.kind = K_AFL; r.bank = 2'd0; end
      32'h05C: begin r.kind = K_AFL; r.bank = 2'd1; end
      32'h064: begin r.kind = K_AFL; r.bank = 2'd2; end
      32'h06C: begin r.kind = K_AFL; r.bank = 2'd3; end
      32'h058: begin r.kind = K_AFU; r.bank = 2'd0; end
      32'h060: begin r.kind = K_AFU; r.bank = 2'd1; end
      32'h068: begin r.kind = K_AFU; r.bank = 2'd2; end
      32'h070: begin r.kind = K_AFU; r.bank = 2'd3; end
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bgp_sync.sv
module bgp_sync #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bgp_decode.sv
module bgp_decode
  import bgp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output bgp_kind_e             kind,
  output logic [BGP_BANK_W-1:0] bank
);
  bgp_dec_t d;

  always_comb begin
    d    = bgp_map(32'(addr));
    hit  = d.hit;
    kind = d.kind;
    bank = d.bank;
  end
endmodule

// File: rtl/bgp_bank.sv
module bgp_bank
  import bgp_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  bgp_kind_e        kind,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_s,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] lat_q,
  output logic [PIN_W-1:0] setw_q,
  output logic [PIN_W-1:0] ren_q,
  output logic [PIN_W-1:0] fen_q,
  output logic [PIN_W-1:0] edg_q,
  output logic [PIN_W-1:0] afl_q,
  output logic [PIN_W-1:0] afu_q,
  output logic [PIN_W-1:0] lvl
);
  logic [PIN_W-1:0] pin_p;
  logic [PIN_W-1:0] evt;
  logic [PIN_W-1:0] edg_d;

  assign lvl = (lat_q & dir_q) | (pin_s & ~dir_q);
  assign evt = ~dir_q & ((ren_q & pin_s & ~pin_p) | (fen_q & ~pin_s & pin_p));

  always_comb begin
    edg_d = edg_q;
    if (we && kind == K_EDG) edg_d = edg_q & ~wdata;
    edg_d = edg_d | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lat_q  <= '0;
      setw_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      edg_q  <= '0;
      afl_q  <= '0;
      afu_q  <= '0;
      pin_p  <= '0;
    end else begin
      pin_p <= pin_s;
      edg_q <= edg_d;
      if (we) begin
        case (kind)
          K_DIR: dir_q <= wdata;
          K_SET: begin lat_q <= lat_q | wdata; setw_q <= wdata; end
          K_CLR: lat_q <= lat_q & ~wdata;
          K_REN: ren_q <= wdata;
          K_FEN: fen_q <= wdata;
          K_AFL: afl_q <= wdata;
          K_AFU: afu_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl
  import bgp_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [PIN_W-1:0]          req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [PIN_W-1:0]          rsp_rdata,
  output logic                      rsp_err,
  input  logic [BGP_NBANK*PIN_W-1:0] pin_in,
  output logic [BGP_NBANK*PIN_W-1:0] pin_oe,
  output logic [BGP_NBANK*PIN_W-1:0] pin_out
);
  localparam int PINS = BGP_NBANK * PIN_W;
  localparam logic [PIN_W-1:0] CLR_RD = {(PIN_W/2){2'b10}};

  logic [PINS-1:0]       pin_s;
  logic                  hit;
  bgp_kind_e             kind;
  logic [BGP_BANK_W-1:0] bank;
  logic                  acc;
  logic                  wr;
  logic [PIN_W-1:0]      rd;

  logic [PIN_W-1:0] dir_a  [BGP_NBANK];
  logic [PIN_W-1:0] lat_a  [BGP_NBANK];
  logic [PIN_W-1:0] setw_a [BGP_NBANK];
  logic [PIN_W-1:0] ren_a  [BGP_NBANK];
  logic [PIN_W-1:0] fen_a  [BGP_NBANK];
  logic [PIN_W-1:0] edg_a  [BGP_NBANK];
  logic [PIN_W-1:0] afl_a  [BGP_NBANK];
  logic [PIN_W-1:0] afu_a  [BGP_NBANK];
  logic [PIN_W-1:0] lvl_a  [BGP_NBANK];

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write && hit;

  bgp_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  bgp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .hit(hit), .kind(kind), .bank(bank)
  );

  for (genvar b = 0; b < BGP_NBANK; b++) begin : g_bank
    bgp_bank #(.PIN_W(PIN_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr && (bank == BGP_BANK_W'(b))),
      .kind(kind), .wdata(req_wdata),
      .pin_s(pin_s[b*PIN_W +: PIN_W]),
      .dir_q(dir_a[b]), .lat_q(lat_a[b]), .setw_q(setw_a[b]),
      .ren_q(ren_a[b]), .fen_q(fen_a[b]), .edg_q(edg_a[b]),
      .afl_q(afl_a[b]), .afu_q(afu_a[b]), .lvl(lvl_a[b])
    );
    assign pin_oe[b*PIN_W +: PIN_W]  = dir_a[b];
    assign pin_out[b*PIN_W +: PIN_W] = lat_a[b] & dir_a[b];
  end

  always_comb begin
    rd = '0;
    if (hit) begin
      case (kind)
        K_LVL:   rd = lvl_a[bank];
        K_DIR:   rd = dir_a[bank];
        K_SET:   rd = setw_a[bank];
        K_CLR:   rd = CLR_RD;
        K_REN:   rd = ren_a[bank];
        K_FEN:   rd = fen_a[bank];
        K_EDG:   rd = edg_a[bank];
        K_AFL:   rd = afl_a[bank];
        K_AFU:   rd = afu_a[bank];
        default: rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd;
      rsp_err   <= !hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bgp_chk.sv
module bgp_chk #(
  parameter int PIN_W = 32,
  parameter int PINS  = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PIN_W-1:0] rsp_rdata,
  input logic             rsp_err,
  input logic [PINS-1:0]  pin_oe,
  input logic [PINS-1:0]  pin_out
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!rsp_valid && pin_oe == '0 && pin_out == '0)); // R1
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n) (pin_out & ~pin_oe) == '0); // R5
  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_ready && req_write) |=> ($stable(pin_out) && $stable(pin_oe))); // R2
  AST_ERR_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_err) |-> rsp_rdata == '0); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R10
endmodule

bind bgpio_ctrl bgp_chk #(.PIN_W(PIN_W), .PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/sim_bgpio_ctrl.sv
`timescale 1ns/1ps
module sim_bgpio_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_oe;
  logic [127:0] pin_out;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   bp = 1'b0;
  bit   done = 1'b0;
  int   bp_cnt = 0;

  always #10 clk = ~clk;

  bgpio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                      input logic [31:0] exp_d, input logic exp_e, input string tag);
    exp_t e;
    e.d = wr ? 32'h0 : exp_d;
    e.e = exp_e;
    e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    sb.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 32'h0, 1'b0, tag);
  endtask

  task automatic rreg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected responses and compares at the accepting cycle
  initial begin
    bit          held = 1'b0;
    logic [31:0] hd = '0;
    logic        he = 1'b0;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (held)
        check(rsp_valid && rsp_rdata == hd && rsp_err == he, "R10 held response",
              {rsp_valid, rsp_err, rsp_rdata}, {1'b1, he, hd});
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 response without request", {95'h0, rsp_err, rsp_rdata}, 128'h0);
        end else begin
          e = sb.pop_front();
          check(rsp_rdata == e.d && rsp_err == e.e, e.tag, {rsp_err, rsp_rdata}, {e.e, e.d});
        end
      end
      held = rsp_valid && !rsp_ready;
      hd = rsp_rdata;
      he = rsp_err;
      @(posedge clk);
      #2;
      bp_cnt++;
      rsp_ready = bp ? (bp_cnt % 3 != 0) : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 128'h0, 128'h1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pin_oe == '0 && pin_out == '0, "R1 pins after reset", {pin_oe[63:0], pin_out[63:0]}, 128'h0);
    check(!rsp_valid, "R1 no response in reset", {127'h0, rsp_valid}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", {127'h0, req_ready}, 128'h1);
    rreg(12'h00C, 32'h0, "R1 dir bank0 zero");
    rreg(12'h100, 32'h0, "R1 level bank3 zero");
    rreg(12'h01C, 32'h0, "R1 set bank1 zero");

    // R2 set, R4 level mix
    pin_in[31:0] = 32'h0000_0F0F;
    wreg(12'h018, 32'h0000_00F0, "R2 write set");
    wreg(12'h00C, 32'h0000_00FF, "R5 write dir");
    rreg(12'h000, 32'h0000_0FF0, "R4 level bank0");
    wreg(12'h018, 32'h0000_0003, "R2 second set");
    rreg(12'h018, 32'h0000_0003, "R2 set readback");
    drain();
    check(pin_out[31:0] == 32'hF3 && pin_oe[31:0] == 32'hFF, "R2 latch on pins",
          {pin_oe[31:0], pin_out[31:0]}, {32'hFF, 32'hF3});

    // R3 clear, R5 gating
    wreg(12'h024, 32'h0000_0011, "R3 write clear");
    rreg(12'h024, 32'hAAAA_AAAA, "R3 clear readback constant");
    drain();
    check(pin_out[31:0] == 32'hE2, "R3 latch cleared", pin_out[31:0], 32'hE2);
    wreg(12'h00C, 32'h0000_000F, "R5 narrow dir");
    drain();
    check(pin_out[31:0] == 32'h02 && pin_oe[31:0] == 32'h0F, "R5 input stops driving",
          {pin_oe[31:0], pin_out[31:0]}, {32'h0F, 32'h02});

    // R6 map and bank independence, under back-pressure (R10)
    bp = 1'b1;
    wreg(12'h10C, 32'hFFFF_0000, "R6 dir bank3");
    wreg(12'h118, 32'h1234_5678, "R6 set bank3");
    rreg(12'h010, 32'h0, "R6 dir bank1 untouched");
    wreg(12'h064, 32'hCAFE_F00D, "R6 alt-low bank2");
    wreg(12'h068, 32'h0BAD_BEEF, "R6 alt-high bank2");
    wreg(12'h054, 32'h0000_0001, "R6 alt-low bank0");
    rreg(12'h064, 32'hCAFE_F00D, "R6 alt-low bank2 read");
    rreg(12'h068, 32'h0BAD_BEEF, "R6 alt-high bank2 read");
    rreg(12'h054, 32'h0000_0001, "R6 alt-low bank0 read");
    rreg(12'h06C, 32'h0, "R6 alt-low bank3 untouched");
    rreg(12'h10C, 32'hFFFF_0000, "R6 dir bank3 read");
    wreg(12'h13C, 32'h0000_0001, "R6 fall bank3");
    rreg(12'h13C, 32'h0000_0001, "R6 fall bank3 read");
    drain();
    check(pin_out[127:96] == 32'h1234_0000, "R6 bank3 pins", pin_out[127:96], 32'h1234_0000);

    // R7 edge capture
    wreg(12'h034, 32'h0000_0005, "R7 rise bank1");
    wreg(12'h040, 32'h0000_0002, "R7 fall bank1");
    wreg(12'h030, 32'h0000_00FF, "R7 rise bank0");
    wreg(12'h03C, 32'h0000_00FF, "R7 fall bank0");
    rreg(12'h034, 32'h0000_0005, "R6 rise bank1 read");
    drain();
    pin_in[63:32] = 32'h7;
    pin_in[31:0]  = 32'h0000_0FF0;
    repeat (6) @(negedge clk);
    rreg(12'h04C, 32'h0000_0005, "R7 rising events bank1");
    rreg(12'h048, 32'h0000_00F0, "R7 output pins ignored bank0");
    rreg(12'h000, 32'h0000_0FF2, "R4 level after pin change");
    drain();
    pin_in[63:32] = 32'h4;
    repeat (6) @(negedge clk);
    rreg(12'h04C, 32'h0000_0007, "R7 falling event sticky");

    // R8 clear of events
    wreg(12'h04C, 32'h0000_0004, "R8 clear one event");
    rreg(12'h04C, 32'h0000_0003, "R8 partial clear");
    wreg(12'h04C, 32'h0000_0003, "R8 clear rest");
    rreg(12'h04C, 32'h0, "R8 all cleared");
    drain();
    bp = 1'b0;

    // R9 unmapped offsets
    xfer(1'b0, 12'h074, 32'h0, 32'h0, 1'b1, "R9 unmapped read");
    xfer(1'b0, 12'h002, 32'h0, 32'h0, 1'b1, "R9 unaligned read");
    xfer(1'b1, 12'h0FC, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 unmapped write");
    xfer(1'b1, 12'h11C, 32'hFFFF_FFFF, 32'h0, 1'b1, "R9 unmapped write near set");
    rreg(12'h00C, 32'h0000_000F, "R9 dir bank0 unchanged");
    drain();
    check(pin_out[31:0] == 32'h02 && pin_oe[63:32] == 32'h0, "R9 pins unchanged",
          {pin_oe[63:32], pin_out[31:0]}, {32'h0, 32'h02});
    check(sb.size() == 0, "R10 all responses returned", 128'(sb.size()), 128'h0);

    done = 1'b1;
    report();
  end
endmodule